// File: doc/BRIEF.md
# Execution Core: Register Bank, Four-Function ALU and Sign Flags

This block is the arithmetic heart of a small 16-bit load/store datapath. It holds eight general-purpose registers. The registers have two combinational read ports and one write port. Register indices come from fields of the current instruction, steered by two select controls. One of these selects can force the destination to register 7, so that a return address can be saved.

A four-operation ALU combines the first source register with a second operand. Instruction bit 5 picks that operand: either a second register or a sign-extended 5-bit constant. The ALU result leaves the block as a bus drive, qualified by an enable. The first source value is also exported, for address arithmetic elsewhere. A three-bit sign register classifies the shared bus value as negative, zero or positive when asked. The surrounding sequencer issues the per-cycle controls and owns the bus.

Only the low 12 bits of the instruction register enter the block, because the opcode nibble is decoded elsewhere.

Top module: `exec_core`

## Requirements
- R1: While reset is active, and after it is released, every register reads 0x0000 and the flags read 3'b010.
- R2: With `dst_sel_i`=0, the write target is `ir_i[11:9]`. With `dst_sel_i`=1, the target is register 7 whatever `ir_i[11:9]` holds, and no other register changes.
- R3: `src1_o` shows, in the same cycle, the register indexed by `ir_i[11:9]` when `src1_sel_i`=0, or by `ir_i[8:6]` when `src1_sel_i`=1.
- R4: On a rising edge with `reg_we_i`=1, the target register takes `bus_i`. With `reg_we_i`=0, no register changes.
- R5: The second ALU operand is the register indexed by `ir_i[2:0]` when `ir_i[5]`=0. When `ir_i[5]`=1, it is `ir_i[4:0]` sign-extended to 16 bits.
- R6: `alu_op_i` encodes 2'b00 = sum modulo 2^16, 2'b01 = bitwise AND, 2'b10 = bitwise inverse of the first operand, 2'b11 = first operand unchanged.
- R7: With `alu_drive_i`=1, `bus_drv_o` carries the ALU result and `bus_drv_en_o`=1. Otherwise `bus_drv_o`=0x0000 and `bus_drv_en_o`=0.
- R8: On a rising edge with `cc_we_i`=1, the flags {N,Z,P} (bit 2, bit 1, bit 0) become 100 if `bus_i[15]`=1, 010 if `bus_i`=0x0000, and 001 otherwise. With `cc_we_i`=0, they hold. Exactly one flag is always set.
- R9: A register that is both read and written in one cycle shows its old value until the edge. There is no write-to-read bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ir_i | input | 12 | Low 12 bits of the instruction register |
| bus_i | input | 16 | Current value of the shared bus |
| reg_we_i | input | 1 | Write the bus into the target register |
| cc_we_i | input | 1 | Sample the bus into the sign flags |
| alu_op_i | input | 2 | ALU operation select |
| dst_sel_i | input | 1 | 0: target from ir[11:9]; 1: register 7 |
| src1_sel_i | input | 1 | 0: first source from ir[11:9]; 1: from ir[8:6] |
| alu_drive_i | input | 1 | Place the ALU result on the bus |
| bus_drv_o | output | 16 | ALU bus drive, zero when idle |
| bus_drv_en_o | output | 1 | Bus drive enable |
| src1_o | output | 16 | First source register value |
| cc_o | output | 3 | Sign flags {N,Z,P} |

## Verification
The bench targets four failure modes:
- A write while `dst_sel_i` is high with a nonzero `ir_i[11:9]`. A broken override would corrupt that numbered register instead of register 7.
- Immediates with bit 4 set. A design that zero-extends would produce sums off by 0xFFE0.
- Flag samples of 0x8000, 0x0000 and 0x0001, plus a disabled sample. A wrong sign test, or a latch without its enable, would show the wrong flag or fail to hold.
- A write with a read of the same register in one cycle, and a sum that wraps past 0xFFFF. A bypassed design would expose the new value early, and a wide adder would not wrap.

// File: rtl/exec_core_pkg.sv
package exec_core_pkg;
  localparam int DATA_W   = 16;
  localparam int IDX_W    = 3;
  localparam int NUM_REGS = 1 << IDX_W;
  localparam int IMM_W    = 5;
  localparam int IR_W     = 12;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'b00,
    ALU_AND  = 2'b01,
    ALU_NOT  = 2'b10,
    ALU_PASS = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic pos;
  } nzp_t;
endpackage

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int W  = 16,
  parameter int N  = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] mem_q [N];
  logic [W-1:0] mem_d [N];

  for (genvar i = 0; i < N; i++) begin : g_entry
    logic hit;
    assign hit = we && (waddr == AW'(i));

    always_comb begin
      mem_d[i] = mem_q[i];
      if (hit) mem_d[i] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[i] <= '0;
      else        mem_q[i] <= mem_d[i];
    end

    // R4: entries not targeted keep their contents
    assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && waddr == AW'(i)) |=> $stable(mem_q[i]));
    // R4: a targeted entry takes the write data at the edge
    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == AW'(i)) |=> mem_q[i] == $past(wdata));
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_core_pkg::*;
#(
  parameter int W = 16,
  parameter int IW = 5
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b_reg,
  input  logic [IW-1:0]  imm,
  input  logic           use_imm,
  output logic [W-1:0]   y
);
  logic [W-1:0] b_imm;
  logic [W-1:0] b;

  assign b_imm = {{(W-IW){imm[IW-1]}}, imm};
  assign b     = use_imm ? b_imm : b_reg;

  always_comb begin
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_AND:  y = a & b;
      ALU_NOT:  y = ~a;
      ALU_PASS: y = a;
    endcase
  end
endmodule

// File: rtl/nzp_flags.sv
module nzp_flags
  import exec_core_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] bus,
  output logic [2:0]   flags
);
  nzp_t cc_q, cc_d, cls;

  always_comb begin
    cls.neg  = bus[W-1];
    cls.zero = (bus == '0);
    cls.pos  = !bus[W-1] && (bus != '0);
    cc_d     = we ? cls : cc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cc_q <= '{neg: 1'b0, zero: 1'b1, pos: 1'b0};
    else        cc_q <= cc_d;
  end

  assign flags = cc_q;

  // R8: exactly one flag set at all times
  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cc_q) == 1);
  // R8: flags hold while sampling is off
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cc_q));
endmodule

// File: rtl/exec_core.sv
module exec_core
  import exec_core_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IR_W-1:0] ir_i,
  input  logic [W-1:0]  bus_i,
  input  logic          reg_we_i,
  input  logic          cc_we_i,
  input  logic [1:0]    alu_op_i,
  input  logic          dst_sel_i,
  input  logic          src1_sel_i,
  input  logic          alu_drive_i,
  output logic [W-1:0]  bus_drv_o,
  output logic          bus_drv_en_o,
  output logic [W-1:0]  src1_o,
  output logic [2:0]    cc_o
);
  localparam logic [IDX_W-1:0] LINK_IDX = IDX_W'(NUM_REGS - 1);

  // reset bridge: asserts at once, releases on the second edge
  logic rst_meta_q, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  logic [IDX_W-1:0] dst_idx, s1_idx, s2_idx;
  logic [W-1:0]     s1_val, s2_val, alu_y;

  always_comb begin
    dst_idx = dst_sel_i  ? LINK_IDX : ir_i[11:9];
    s1_idx  = src1_sel_i ? ir_i[8:6] : ir_i[11:9];
    s2_idx  = ir_i[2:0];
  end

  gpr_bank #(.W(W), .N(NUM_REGS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .we      (reg_we_i),
    .waddr   (dst_idx),
    .wdata   (bus_i),
    .raddr_a (s1_idx),
    .raddr_b (s2_idx),
    .rdata_a (s1_val),
    .rdata_b (s2_val)
  );

  exec_alu #(.W(W), .IW(IMM_W)) u_alu (
    .op      (alu_op_e'(alu_op_i)),
    .a       (s1_val),
    .b_reg   (s2_val),
    .imm     (ir_i[4:0]),
    .use_imm (ir_i[5]),
    .y       (alu_y)
  );

  nzp_flags #(.W(W)) u_flags (
    .clk   (clk),
    .rst_n (rst_core_n),
    .we    (cc_we_i),
    .bus   (bus_i),
    .flags (cc_o)
  );

  assign bus_drv_o    = alu_drive_i ? alu_y : '0;
  assign bus_drv_en_o = alu_drive_i;
  assign src1_o       = s1_val;

  // R7: no drive while the gate is off
  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    !alu_drive_i |-> (bus_drv_o == '0) && !bus_drv_en_o);
  // R6: pass forwards the first source port unchanged
  assert_pass_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (alu_drive_i && alu_op_i == 2'b11) |-> bus_drv_o == src1_o);
  // R6: inverse shares no set bit with the source and covers every bit
  assert_not_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (alu_drive_i && alu_op_i == 2'b10) |->
      ((bus_drv_o & src1_o) == '0) && ((bus_drv_o | src1_o) == '1));
  // R6: AND never sets a bit the first source lacks
  assert_and_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (alu_drive_i && alu_op_i == 2'b01) |-> (bus_drv_o & ~src1_o) == '0);
endmodule

// File: tb/sim_exec_core.sv
module sim_exec_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] ir_i;
  logic [15:0] bus_i;
  logic        reg_we_i, cc_we_i, dst_sel_i, src1_sel_i, alu_drive_i;
  logic [1:0]  alu_op_i;
  logic [15:0] bus_drv_o, src1_o;
  logic        bus_drv_en_o;
  logic [2:0]  cc_o;

  always #4 clk = ~clk;

  exec_core u0 (
    .clk(clk), .rst_n(rst_n), .ir_i(ir_i), .bus_i(bus_i),
    .reg_we_i(reg_we_i), .cc_we_i(cc_we_i), .alu_op_i(alu_op_i),
    .dst_sel_i(dst_sel_i), .src1_sel_i(src1_sel_i), .alu_drive_i(alu_drive_i),
    .bus_drv_o(bus_drv_o), .bus_drv_en_o(bus_drv_en_o),
    .src1_o(src1_o), .cc_o(cc_o)
  );

  logic [15:0] m_reg [8];
  logic [2:0]  m_cc;
  int errs = 0;
  int checks = 0;
  bit done = 0;

  localparam logic [1:0] OP_ADD = 2'b00, OP_AND = 2'b01, OP_NOT = 2'b10, OP_PASS = 2'b11;

  function automatic logic [11:0] mk(int dr, int s1, bit imm, logic [4:0] lo);
    return {3'(dr), 3'(s1), imm, lo};
  endfunction

  function automatic logic [15:0] ref_alu(logic [1:0] op, logic [15:0] a, logic [15:0] b);
    case (op)
      OP_ADD:  return 16'((32'(a) + 32'(b)) % 65536);
      OP_AND:  return a & b;
      OP_NOT:  return 16'hFFFF ^ a;
      default: return a;
    endcase
  endfunction

  function automatic logic [2:0] ref_nzp(logic [15:0] v);
    if (v[15])       return 3'b100;
    if (v == 16'h0)  return 3'b010;
    return 3'b001;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic [11:0] ir, logic [15:0] bus, bit we, bit cwe,
                      logic [1:0] op, bit ds, bit ss, bit drv);
    logic [15:0] a, b, res, busv;
    ir_i = ir; reg_we_i = we; cc_we_i = cwe; alu_op_i = op;
    dst_sel_i = ds; src1_sel_i = ss; alu_drive_i = drv;
    a    = m_reg[ss ? ir[8:6] : ir[11:9]];
    b    = ir[5] ? {{11{ir[4]}}, ir[4:0]} : m_reg[ir[2:0]];
    res  = ref_alu(op, a, b);
    busv = drv ? res : bus;
    bus_i = busv;
    #1;
    chk({tag, " src1"}, src1_o, a);
    chk({tag, " bus"}, bus_drv_o, drv ? res : 16'h0);
    chk({tag, " en"}, {15'h0, bus_drv_en_o}, {15'h0, drv});
    chk({tag, " cc"}, {13'h0, cc_o}, {13'h0, m_cc});
    @(posedge clk);
    if (we)  m_reg[ds ? 7 : int'(ir[11:9])] = busv;
    if (cwe) m_cc = ref_nzp(busv);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    ir_i = '0; bus_i = '0; reg_we_i = 0; cc_we_i = 0; alu_op_i = '0;
    dst_sel_i = 0; src1_sel_i = 1; alu_drive_i = 0;
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_cc = 3'b010;
    repeat (2) @(negedge clk);
    // R1: state while reset is held, even with write requests
    reg_we_i = 1; cc_we_i = 1; bus_i = 16'h8001;
    @(negedge clk);
    reg_we_i = 0; cc_we_i = 0;
    for (int i = 0; i < 8; i++) begin
      ir_i = mk(0, i, 0, 0); #1;
      chk("R1 reg in reset", src1_o, 16'h0);
    end
    chk("R1 flags in reset", {13'h0, cc_o}, 16'h0002);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      ir_i = mk(0, i, 0, 0); #1;
      chk("R1 reg after release", src1_o, 16'h0);
    end

    step("R4 write r3",        mk(3,0,0,0), 16'h1234, 1,0,OP_PASS,0,1,0);
    step("R2 override to r7",  mk(2,0,0,0), 16'hBEEF, 1,0,OP_PASS,1,1,0);
    step("R2 r2 untouched",    mk(0,2,0,0), 16'h0,    0,0,OP_PASS,0,1,0);
    step("R3 src from 11:9",   mk(7,3,0,0), 16'h0,    0,0,OP_PASS,0,0,0);
    step("R3 src from 8:6",    mk(7,3,0,0), 16'h0,    0,0,OP_PASS,0,1,0);
    step("R4 hold no write",   mk(3,0,0,0), 16'hFFFF, 0,0,OP_PASS,0,1,0);
    step("R4 read back r3",    mk(0,3,0,0), 16'h0,    0,0,OP_PASS,0,1,0);
    step("R4 load r1",         mk(1,0,0,0), 16'h0005, 1,0,OP_PASS,0,1,0);
    step("R5 R6 add reg",      mk(4,3,0,1), 16'h0,    1,1,OP_ADD,0,1,1);
    step("R5 add imm neg",     mk(5,1,1,5'h1F), 16'h0, 1,1,OP_ADD,0,1,1);
    step("R5 add imm pos",     mk(5,1,1,5'h0F), 16'h0, 1,1,OP_ADD,0,1,1);
    step("R5 add imm -16",     mk(6,1,1,5'h10), 16'h0, 1,1,OP_ADD,0,1,1);
    step("R6 and",             mk(0,7,0,3), 16'h0,    0,0,OP_AND,0,1,1);
    step("R6 not",             mk(0,7,0,0), 16'h0,    0,0,OP_NOT,0,1,1);
    step("R6 pass",            mk(0,3,0,0), 16'h0,    0,0,OP_PASS,0,1,1);
    step("R6 load ffff",       mk(6,0,0,0), 16'hFFFF, 1,0,OP_PASS,0,1,0);
    step("R6 add wraps",       mk(2,6,1,5'h01), 16'h0, 1,1,OP_ADD,0,1,1);
    step("R6 wrap readback",   mk(0,2,0,0), 16'h0,    0,0,OP_PASS,0,1,0);
    step("R7 gate off",        mk(0,7,0,3), 16'h0,    0,0,OP_ADD,0,1,0);
    step("R8 negative",        mk(0,0,0,0), 16'h8000, 0,1,OP_PASS,0,1,0);
    step("R8 zero",            mk(0,0,0,0), 16'h0000, 0,1,OP_PASS,0,1,0);
    step("R8 positive",        mk(0,0,0,0), 16'h0001, 0,1,OP_PASS,0,1,0);
    step("R8 hold off",        mk(0,0,0,0), 16'h8000, 0,0,OP_PASS,0,1,0);
    step("R8 hold seen",       mk(0,0,0,0), 16'h0000, 0,0,OP_PASS,0,1,0);
    step("R9 same cycle rw",   mk(3,3,0,0), 16'hAAAA, 1,1,OP_PASS,0,1,0);
    step("R9 new value after", mk(3,3,0,0), 16'h0,    0,0,OP_PASS,0,1,0);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step("RND R3 R5 R6 R7 R8", r[11:0], 16'($urandom), r[12], r[13], r[15:14],
           r[16], r[17], r[18]);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule